// File: doc/BRIEF.md
# Thread-Interleaved Fetch and Replay Controller

This block decides which hardware thread issues into a thread-interleaved pipeline on every cycle and holds one program counter per thread. Threads take turns in a fixed rotation, one slot per cycle, so the time an instruction takes never depends on what its neighbours in the pipeline are doing. The controller presents the selected thread number and the PC to fetch for that slot.

A thread can be held up by an outstanding main-memory access or by a deadline stall raised by the timer unit. A held thread does not freeze the pipeline. At its next turn it fetches the same PC again and a replay flag marks that slot as a repeat. A thread that was not held steps its PC by one instruction for its next turn. A taken branch or an exception can redirect any thread to a new address. A redirect beats both a stall and the step. A pulse marks the last slot of each rotation, so the deadline timers can count down once per scheduling round.

Top module: `fetch_replay_ctl`

## Requirements
- R1: While reset is low, and on the first cycle after it, the slot thread is 0 and the replay flag is 0. Until a thread's first turn it presents the PC BASE_ADDR + t*THREAD_STRIDE, where t is its thread number (defaults 0x1000 and 0x1000).
- R2: The slot thread steps 0,1,...,NUM_THREADS-1 and then wraps to 0, one thread per clock cycle, whatever the inputs.
- R3: If the slot thread is not stalled and not redirected at the end of its slot, then at its next turn its PC is the previous PC plus INSTR_BYTES (default 4) and the replay flag is 0.
- R4: If bit t of mem_wait_i is 1 at the end of thread t's slot, then at its next turn thread t presents the same PC again with the replay flag at 1.
- R5: If bit t of dl_wait_i is 1 at the end of thread t's slot, the thread replays in the same way as in R4.
- R6: The stall bits of a thread are sampled only at the end of that thread's own slot. A stall bit raised during another thread's slot has no effect.
- R7: When redir_valid_i is 1 at a clock edge, the thread named by redir_tid_i presents redir_pc_i at its next turn with the replay flag at 0, whether or not that thread holds the current slot. A redirect that names a thread number of NUM_THREADS or more changes no PC.
- R8: A redirect for the slot thread takes priority over that thread's stall and over its step.
- R9: round_end_o is 1 exactly during the slot of thread NUM_THREADS-1.
- R10: A stall affects only the thread's next turn. If the thread is not stalled on that replayed slot, its PC steps at the turn after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_wait_i | input | NUM_THREADS | Per-thread flag: a main-memory access is outstanding |
| dl_wait_i | input | NUM_THREADS | Per-thread deadline stall from the timer unit |
| redir_valid_i | input | 1 | Redirect request |
| redir_tid_i | input | TID_W | Thread to redirect |
| redir_pc_i | input | PC_W | Redirect target address |
| slot_tid_o | output | TID_W | Thread issuing in this slot |
| slot_pc_o | output | PC_W | PC to fetch for this slot |
| slot_replay_o | output | 1 | This slot repeats the thread's previous PC |
| round_end_o | output | 1 | Last slot of the rotation |

## Verification
All outputs come straight from registers. The slot thread and round_end_o therefore change one clock edge after the previous slot. A stall, step or redirect decided at an edge becomes visible only at that thread's next turn, NUM_THREADS cycles after its previous slot. The bench drives inputs and samples outputs at the falling edge. A reference model built from the requirements advances once per rising edge, so each falling-edge sample is compared with the state that the last edge should have produced. The checker keeps the last issued PC, the stall outcome and any pending redirect for each thread, and checks each thread's next turn against them.

// File: rtl/fetch_replay_pkg.sv
package fetch_replay_pkg;

  typedef enum logic [1:0] {
    UPD_IDLE,
    UPD_REPLAY,
    UPD_STEP,
    UPD_LOAD
  } pc_upd_e;

  // redirect > own-slot stall > own-slot step
  function automatic pc_upd_e pick_upd(input logic redir_hit,
                                       input logic slot_hit,
                                       input logic stall);
    if (redir_hit)      return UPD_LOAD;
    else if (!slot_hit) return UPD_IDLE;
    else if (stall)     return UPD_REPLAY;
    else                return UPD_STEP;
  endfunction

endpackage

// File: rtl/fetch_slot_ctr.sv
module fetch_slot_ctr #(
  parameter int unsigned NUM_SLOTS = 6,
  parameter int unsigned TID_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [TID_W-1:0] slot_o,
  output logic             last_o
);
  localparam logic [TID_W-1:0] LAST_SLOT = TID_W'(NUM_SLOTS - 1);

  logic [TID_W-1:0] slot_q, slot_d;

  assign last_o = (slot_q == LAST_SLOT);
  assign slot_o = slot_q;

  always_comb begin
    if (last_o) slot_d = '0;
    else        slot_d = slot_q + TID_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else         slot_q <= slot_d;
  end
endmodule

// File: rtl/fetch_pc_lane.sv
module fetch_pc_lane
  import fetch_replay_pkg::*;
#(
  parameter int unsigned     PC_W        = 32,
  parameter int unsigned     INSTR_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_PC    = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            slot_hit_i,
  input  logic            stall_i,
  input  logic            redir_hit_i,
  input  logic [PC_W-1:0] redir_pc_i,
  output logic [PC_W-1:0] pc_o,
  output logic            replay_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

  pc_upd_e         upd;
  logic [PC_W-1:0] pc_q, pc_d;
  logic            replay_q, replay_d;

  always_comb begin
    upd      = pick_upd(redir_hit_i, slot_hit_i, stall_i);
    pc_d     = pc_q;
    replay_d = replay_q;
    unique case (upd)
      UPD_LOAD: begin
        pc_d     = redir_pc_i;
        replay_d = 1'b0;
      end
      UPD_STEP: begin
        pc_d     = pc_q + STEP;
        replay_d = 1'b0;
      end
      UPD_REPLAY: replay_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= RESET_PC;
      replay_q <= 1'b0;
    end else begin
      pc_q     <= pc_d;
      replay_q <= replay_d;
    end
  end

  assign pc_o     = pc_q;
  assign replay_o = replay_q;
endmodule

// File: rtl/fetch_issue_mux.sv
module fetch_issue_mux #(
  parameter int unsigned NUM_THREADS = 6,
  parameter int unsigned PC_W        = 32,
  parameter int unsigned TID_W       = 3
) (
  input  logic [TID_W-1:0]       sel_i,
  input  logic [PC_W-1:0]        pc_i [NUM_THREADS],
  input  logic [NUM_THREADS-1:0] replay_i,
  output logic [PC_W-1:0]        pc_o,
  output logic                   replay_o
);
  always_comb begin
    pc_o     = '0;
    replay_o = 1'b0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (sel_i == TID_W'(t)) begin
        pc_o     = pc_i[t];
        replay_o = replay_i[t];
      end
    end
  end
endmodule

// File: rtl/fetch_replay_ctl.sv
module fetch_replay_ctl #(
  parameter int unsigned     NUM_THREADS   = 6,
  parameter int unsigned     PC_W          = 32,
  parameter int unsigned     INSTR_BYTES   = 4,
  parameter logic [PC_W-1:0] BASE_ADDR     = 32'h0000_1000,
  parameter logic [PC_W-1:0] THREAD_STRIDE = 32'h0000_1000,
  localparam int unsigned    TID_W         = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_THREADS-1:0] mem_wait_i,
  input  logic [NUM_THREADS-1:0] dl_wait_i,
  input  logic                   redir_valid_i,
  input  logic [TID_W-1:0]       redir_tid_i,
  input  logic [PC_W-1:0]        redir_pc_i,
  output logic [TID_W-1:0]       slot_tid_o,
  output logic [PC_W-1:0]        slot_pc_o,
  output logic                   slot_replay_o,
  output logic                   round_end_o
);
  logic [TID_W-1:0]       slot;
  logic [PC_W-1:0]        lane_pc [NUM_THREADS];
  logic [NUM_THREADS-1:0] lane_replay;

  fetch_slot_ctr #(
    .NUM_SLOTS(NUM_THREADS),
    .TID_W    (TID_W)
  ) u_slot (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .slot_o(slot),
    .last_o(round_end_o)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_lane
    localparam logic [PC_W-1:0] LANE_BASE = BASE_ADDR + PC_W'(t) * THREAD_STRIDE;

    logic slot_hit, redir_hit, stall;

    assign slot_hit  = (slot == TID_W'(t));
    assign redir_hit = redir_valid_i && (redir_tid_i == TID_W'(t));
    assign stall     = mem_wait_i[t] | dl_wait_i[t];

    fetch_pc_lane #(
      .PC_W       (PC_W),
      .INSTR_BYTES(INSTR_BYTES),
      .RESET_PC   (LANE_BASE)
    ) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .slot_hit_i (slot_hit),
      .stall_i    (stall),
      .redir_hit_i(redir_hit),
      .redir_pc_i (redir_pc_i),
      .pc_o       (lane_pc[t]),
      .replay_o   (lane_replay[t])
    );
  end

  fetch_issue_mux #(
    .NUM_THREADS(NUM_THREADS),
    .PC_W       (PC_W),
    .TID_W      (TID_W)
  ) u_mux (
    .sel_i   (slot),
    .pc_i    (lane_pc),
    .replay_i(lane_replay),
    .pc_o    (slot_pc_o),
    .replay_o(slot_replay_o)
  );

  assign slot_tid_o = slot;
endmodule

// File: rtl/fetch_replay_chk.sv
module fetch_replay_chk #(
  parameter int unsigned     NUM_THREADS   = 6,
  parameter int unsigned     PC_W          = 32,
  parameter int unsigned     INSTR_BYTES   = 4,
  parameter logic [PC_W-1:0] BASE_ADDR     = 32'h0000_1000,
  parameter logic [PC_W-1:0] THREAD_STRIDE = 32'h0000_1000,
  parameter int unsigned     TID_W         = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NUM_THREADS-1:0] mem_wait_i,
  input logic [NUM_THREADS-1:0] dl_wait_i,
  input logic                   redir_valid_i,
  input logic [TID_W-1:0]       redir_tid_i,
  input logic [PC_W-1:0]        redir_pc_i,
  input logic [TID_W-1:0]       slot_tid_o,
  input logic [PC_W-1:0]        slot_pc_o,
  input logic                   slot_replay_o,
  input logic                   round_end_o
);
  localparam logic [TID_W-1:0] LAST_TID = TID_W'(NUM_THREADS - 1);

  logic [PC_W-1:0]        last_pc_q [NUM_THREADS];
  logic [PC_W-1:0]        pend_pc_q [NUM_THREADS];
  logic [NUM_THREADS-1:0] issued_q, pend_q, stall_q, rhit;
  logic [PC_W-1:0]        base_pc;

  always_comb begin
    for (int t = 0; t < NUM_THREADS; t++)
      rhit[t] = redir_valid_i && (redir_tid_i == TID_W'(t));
  end

  assign base_pc = BASE_ADDR + PC_W'(slot_tid_o) * THREAD_STRIDE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issued_q <= '0;
      pend_q   <= '0;
      stall_q  <= '0;
      for (int t = 0; t < NUM_THREADS; t++) begin
        last_pc_q[t] <= '0;
        pend_pc_q[t] <= '0;
      end
    end else begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        if (rhit[t]) begin
          pend_q[t]    <= 1'b1;
          pend_pc_q[t] <= redir_pc_i;
          stall_q[t]   <= 1'b0;
        end else if (slot_tid_o == TID_W'(t)) begin
          pend_q[t]    <= 1'b0;
        end
        if (slot_tid_o == TID_W'(t)) begin
          issued_q[t]  <= 1'b1;
          last_pc_q[t] <= slot_pc_o;
          if (!rhit[t]) stall_q[t] <= mem_wait_i[t] | dl_wait_i[t];
        end
      end
    end
  end

  p_rr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_tid_o != LAST_TID) |=> (slot_tid_o == $past(slot_tid_o) + TID_W'(1)));

  p_rr_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_tid_o == LAST_TID) |=> (slot_tid_o == '0));

  p_round_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    round_end_o |=> (slot_tid_o == '0));

  p_no_round_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !round_end_o |=> (slot_tid_o != '0));

  p_reset_base_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!issued_q[slot_tid_o] && !pend_q[slot_tid_o]) |-> (slot_pc_o == base_pc && !slot_replay_o));

  p_replay_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issued_q[slot_tid_o] && stall_q[slot_tid_o] && !pend_q[slot_tid_o])
      |-> (slot_replay_o && slot_pc_o == last_pc_q[slot_tid_o]));

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issued_q[slot_tid_o] && !stall_q[slot_tid_o] && !pend_q[slot_tid_o])
      |-> (!slot_replay_o && slot_pc_o == last_pc_q[slot_tid_o] + PC_W'(INSTR_BYTES)));

  p_redir_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q[slot_tid_o] |-> (slot_pc_o == pend_pc_q[slot_tid_o] && !slot_replay_o));
endmodule

bind fetch_replay_ctl fetch_replay_chk #(
  .NUM_THREADS  (NUM_THREADS),
  .PC_W         (PC_W),
  .INSTR_BYTES  (INSTR_BYTES),
  .BASE_ADDR    (BASE_ADDR),
  .THREAD_STRIDE(THREAD_STRIDE),
  .TID_W        (TID_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_wait_i   (mem_wait_i),
  .dl_wait_i    (dl_wait_i),
  .redir_valid_i(redir_valid_i),
  .redir_tid_i  (redir_tid_i),
  .redir_pc_i   (redir_pc_i),
  .slot_tid_o   (slot_tid_o),
  .slot_pc_o    (slot_pc_o),
  .slot_replay_o(slot_replay_o),
  .round_end_o  (round_end_o)
);

// File: tb/tb_fetch_replay_ctl.sv
module tb_fetch_replay_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NT         = 6;
  localparam int NVEC       = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] mem_wait = '0;
  logic [NT-1:0] dl_wait = '0;
  logic          rv = 1'b0;
  logic [2:0]    rtid = '0;
  logic [31:0]   rpc = '0;
  logic [2:0]    tid;
  logic [31:0]   pc;
  logic          replay;
  logic          rend;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_pc [NT];
  logic        exp_rep [NT];
  int          exp_tid;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_replay_ctl dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .mem_wait_i   (mem_wait),
    .dl_wait_i    (dl_wait),
    .redir_valid_i(rv),
    .redir_tid_i  (rtid),
    .redir_pc_i   (rpc),
    .slot_tid_o   (tid),
    .slot_pc_o    (pc),
    .slot_replay_o(replay),
    .round_end_o  (rend)
  );

  // {mem_wait, dl_wait, redir_valid, redir_tid, redir_pc}
  localparam logic [47:0] VEC [NVEC] = '{
    {6'b000000, 6'b000000, 1'b0, 3'd0, 32'h0},
    {6'b000010, 6'b000000, 1'b0, 3'd0, 32'h0},
    {6'b000100, 6'b000000, 1'b0, 3'd0, 32'h0},
    {6'b000000, 6'b001000, 1'b0, 3'd0, 32'h0},
    {6'b111111, 6'b000000, 1'b0, 3'd0, 32'h0},
    {6'b000000, 6'b000000, 1'b1, 3'd1, 32'h0000_4000},
    {6'b000001, 6'b000001, 1'b0, 3'd0, 32'h0},
    {6'b000000, 6'b000000, 1'b0, 3'd0, 32'h0},
    {6'b000000, 6'b000100, 1'b0, 3'd0, 32'h0},
    {6'b101010, 6'b010101, 1'b0, 3'd0, 32'h0},
    {6'b000000, 6'b000000, 1'b1, 3'd4, 32'h0000_5000},
    {6'b100000, 6'b000000, 1'b0, 3'd0, 32'h0},
    {6'b000000, 6'b000000, 1'b0, 3'd0, 32'h0},
    {6'b000000, 6'b000000, 1'b1, 3'd0, 32'h0000_6000},
    {6'b000000, 6'b000000, 1'b0, 3'd0, 32'h0},
    {6'b000100, 6'b000000, 1'b0, 3'd0, 32'h0},
    {6'b000000, 6'b000000, 1'b0, 3'd0, 32'h0},
    {6'b000000, 6'b010000, 1'b0, 3'd0, 32'h0},
    {6'b000000, 6'b000000, 1'b1, 3'd5, 32'h0000_7000},
    {6'b000000, 6'b000000, 1'b0, 3'd0, 32'h0}
  };

  task automatic model_reset();
    for (int t = 0; t < NT; t++) begin
      exp_pc[t]  = 32'h0000_1000 + 32'(t) * 32'h0000_1000;
      exp_rep[t] = 1'b0;
    end
    exp_tid = 0;
  endtask

  task automatic model_step(input logic [NT-1:0] m, input logic [NT-1:0] d,
                            input logic v, input logic [2:0] rt, input logic [31:0] rp);
    int  cur;
    bit  rhit_cur;
    cur      = exp_tid;
    rhit_cur = v && (int'(rt) == cur);
    if (v && int'(rt) < NT) begin
      exp_pc[rt]  = rp;
      exp_rep[rt] = 1'b0;
    end
    if (!rhit_cur) begin
      if (m[cur] | d[cur]) exp_rep[cur] = 1'b1;
      else begin
        exp_pc[cur]  = exp_pc[cur] + 32'd4;
        exp_rep[cur] = 1'b0;
      end
    end
    exp_tid = (cur == NT-1) ? 0 : cur + 1;
  endtask

  task automatic chk(input string tag);
    checks++;
    if (int'(tid) != exp_tid) begin
      fails++;
      $display("FAIL R2 slot thread: actual %0d expected %0d", tid, exp_tid);
    end
    checks++;
    if (rend !== (exp_tid == NT-1)) begin
      fails++;
      $display("FAIL R9 round_end: actual %0b expected %0b", rend, exp_tid == NT-1);
    end
    checks++;
    if (pc !== exp_pc[exp_tid]) begin
      fails++;
      $display("FAIL %s pc thread %0d: actual %h expected %h", tag, exp_tid, pc, exp_pc[exp_tid]);
    end
    checks++;
    if (replay !== exp_rep[exp_tid]) begin
      fails++;
      $display("FAIL %s replay thread %0d: actual %0b expected %0b", tag, exp_tid, replay, exp_rep[exp_tid]);
    end
  endtask

  task automatic cyc(input logic [NT-1:0] m, input logic [NT-1:0] d, input logic v,
                     input logic [2:0] rt, input logic [31:0] rp, input string tag);
    chk(tag);
    mem_wait = m;
    dl_wait  = d;
    rv       = v;
    rtid     = rt;
    rpc      = rp;
    model_step(m, d, v, rt, rp);
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    cyc('0, '0, 1'b0, 3'd0, 32'h0, tag);
  endtask

  task automatic run_to(input int t, input string tag);
    while (exp_tid != t) idle(tag);
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    mem_wait = '0;
    dl_wait  = '0;
    rv       = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    chk("R1");
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: first rotation presents per-thread base addresses
    for (int i = 0; i < NT; i++) idle("R1");

    // table walk: R2 order, R3 step, R4 memory stall
    for (int i = 0; i < NVEC; i++)
      cyc(VEC[i][47:42], VEC[i][41:36], VEC[i][35], VEC[i][34:32], VEC[i][31:0], "R3/R4");

    // R5: deadline stall on thread 2
    run_to(2, "R5");
    cyc('0, 6'b000100, 1'b0, 3'd0, 32'h0, "R5");
    run_to(2, "R5");
    chk("R5");

    // R6: stall bit of thread 3 raised in slot 1 only
    run_to(1, "R6");
    cyc(6'b001000, 6'b001000, 1'b0, 3'd0, 32'h0, "R6");
    run_to(3, "R6");
    idle("R6");
    run_to(3, "R6");
    chk("R6");

    // R10: stall thread 4 once, then free
    run_to(4, "R10");
    cyc(6'b010000, '0, 1'b0, 3'd0, 32'h0, "R10");
    run_to(4, "R10");
    idle("R10");
    run_to(4, "R10");
    chk("R10");

    // R7: redirect thread 4 during slot 0
    run_to(0, "R7");
    cyc('0, '0, 1'b1, 3'd4, 32'h0000_8000, "R7");
    run_to(4, "R7");
    chk("R7");

    // R7: out-of-range thread number changes no PC
    cyc('0, '0, 1'b1, 3'd7, 32'hDEAD_0000, "R7");
    for (int i = 0; i < NT; i++) idle("R7");

    // R8: redirect beats stall and step on the slot thread
    run_to(2, "R8");
    cyc(6'b000100, 6'b000100, 1'b1, 3'd2, 32'h0000_9000, "R8");
    run_to(5, "R8");
    cyc('0, '0, 1'b1, 3'd5, 32'h0000_A000, "R8");
    run_to(2, "R8");
    chk("R8");
    run_to(5, "R8");
    chk("R8");

    // R1: asynchronous reset mid-run
    run_to(3, "R1");
    do_reset();
    for (int i = 0; i < NT; i++) idle("R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule